// File: doc/BRIEF.md
# Cascadable Segment Data Input Chain

This block is the data input stage of one column-driver slice. The slice owns `COLS` columns, 160 by default. Several identical slices share one data bus and one shift clock. An active-low enable token passes from slice to slice along a chain, so the controller needs no per-slice select line. A slice takes bus words only while its token input is low and it has not yet filled its line. Once it holds a full line it pulls its own token output low, and the next slice in the chain starts accepting data.

All inputs are synchronous to `clk`. The block acts on falling edges of the shift strobe `sclk` and of the line strobe `lp`, and it finds those edges by comparing each input with its value on the previous clock. A width select chooses a 4-bit or an 8-bit bus word. A direction input sets the order in which columns fill. It also decides which of the two token pins acts as the input and which acts as the output. Each token pin is modelled as separate in, out and output-enable signals.

Each line strobe moves the assembled line into a staging store. On every fourth strobe the block issues a one-cycle write strobe, together with the four lines and the row address it sampled at that strobe, to an external frame memory.

Top module: `seg_chain_in`

## Requirements
- R1: After reset, both token outputs are high, `mem_we` is 0, `mem_blk` is all zero and `mem_row` is 0.
- R2: With `dir`=0, pin A is the token output (`ena_a_oe`=1, `ena_b_oe`=0) and `ena_b_in` is the token input. With `dir`=1 the roles swap. The output-enable lines follow `dir` in the same cycle.
- R3: A falling edge of `sclk` takes a bus word only while the selected token input is 0. Words offered while that input is 1, or only on the unselected pin, leave the line unchanged.
- R4: With `wide`=0, each word carries 4 bits, `din[3]` earliest and `din[0]` last, and `din[7:4]` has no effect.
- R5: With `wide`=1, each word carries 8 bits, `din[7]` earliest and `din[0]` last.
- R6: Number the bits of a line 0, 1, 2 and so on in order of arrival. With `dir`=0, bit k goes to column index COLS-1-k, where index COLS-1 is the first column filled. With `dir`=1, bit k goes to column index k.
- R7: The clock after the edge that completes COLS bits, the token output drops to 0. Further `sclk` edges are then ignored until the next `lp` falling edge.
- R8: An `lp` falling edge returns the token output to 1 on the next clock and clears the line being assembled. If it coincides with an `sclk` falling edge, the word on that edge is dropped.
- R9: On the fourth `lp` falling edge since reset or since the last write, `mem_we` is 1 for exactly one clock. At the same time `mem_blk` holds the four lines, the first captured at bits [COLS-1:0] and the fourth at the top, and `mem_row` holds `row_addr` as sampled at that edge. `mem_blk` and `mem_row` hold their values between writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Shift strobe; the block acts on its falling edge |
| lp | input | 1 | Line strobe; the block acts on its falling edge |
| din | input | 8 | Bus word |
| wide | input | 1 | Bus width: 0 = 4-bit, 1 = 8-bit |
| dir | input | 1 | Fill order and token pin roles |
| row_addr | input | 8 | Frame memory row for the next block write |
| ena_a_in | input | 1 | Token pin A, input value |
| ena_b_in | input | 1 | Token pin B, input value |
| ena_a_out | output | 1 | Token pin A, driven value |
| ena_a_oe | output | 1 | Token pin A, output enable |
| ena_b_out | output | 1 | Token pin B, driven value |
| ena_b_oe | output | 1 | Token pin B, output enable |
| mem_we | output | 1 | One-cycle frame memory write strobe |
| mem_row | output | 8 | Row address of the block write |
| mem_blk | output | 640 | Four staged lines |

## Verification
The assertions check on every cycle that:
- exactly one token pin is driven;
- no word is taken while the selected token input is high;
- the bit count never passes COLS;
- the token output drops right after the completing word and rises right after a line strobe;
- the write strobe lasts one clock, always follows a line strobe, and the written block stays still between strobes.

Only the bench scenarios can show that each bit lands in the right column. The same holds for the nibble and byte bit order, for the high nibble being ignored, for words dropped after the line is full or on the wrong pin, and for the line order inside the written block. The bench shows these by comparing against a queue-based model.

// File: rtl/seg_chain_pkg.sv
package seg_chain_pkg;
  localparam int unsigned DEF_COLS  = 160;
  localparam int unsigned DEF_LINES = 4;
  localparam int unsigned DEF_DW    = 8;
  localparam int unsigned DEF_ROWW  = 8;

  // Column index taking arrival bit (base + j); forward fill from index 0
  // when rev is set, otherwise from the top column downward.
  function automatic int col_pos(input int cols, input int base, input int j,
                                 input logic rev);
    return rev ? (base + j) : (cols - 1 - base - j);
  endfunction

  // Bits carried by one bus word for the selected width.
  function automatic int word_bits(input int dw, input logic wide);
    return wide ? dw : dw / 2;
  endfunction
endpackage

// File: rtl/seg_edge_det.sv
module seg_edge_det #(
  parameter bit FALLING = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig,
  output logic pulse
);
  logic sig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sig_q <= 1'b0;
    else        sig_q <= sig;
  end

  generate
    if (FALLING) begin : g_fall
      assign pulse = sig_q & ~sig;
    end else begin : g_rise
      assign pulse = ~sig_q & sig;
    end
  endgenerate
endmodule

// File: rtl/seg_enable_ctl.sv
module seg_enable_ctl #(
  parameter int unsigned COLS = 160,
  parameter int unsigned DW   = 8,
  localparam int unsigned CNTW = $clog2(COLS + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dir,
  input  logic            wide,
  input  logic            ena_a_in,
  input  logic            ena_b_in,
  input  logic            sclk_fall,
  input  logic            lp_fall,
  output logic            shift_acc,
  output logic [CNTW-1:0] bit_cnt,
  output logic            tok_n,
  output logic            oe_a,
  output logic            oe_b
);
  import seg_chain_pkg::*;

  logic            en_in_n;
  logic            line_full;
  logic [CNTW-1:0] step;

  assign en_in_n   = dir ? ena_a_in : ena_b_in;
  assign line_full = (bit_cnt == CNTW'(COLS));
  assign step      = CNTW'(word_bits(DW, wide));
  assign shift_acc = sclk_fall & ~lp_fall & ~en_in_n & ~line_full;
  assign tok_n     = ~line_full;
  assign oe_a      = ~dir;
  assign oe_b      = dir;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         bit_cnt <= '0;
    else if (lp_fall)   bit_cnt <= '0;
    else if (shift_acc) bit_cnt <= bit_cnt + step;
  end
endmodule

// File: rtl/seg_line_asm.sv
module seg_line_asm #(
  parameter int unsigned COLS = 160,
  parameter int unsigned DW   = 8,
  localparam int unsigned CNTW = $clog2(COLS + 1),
  localparam int unsigned COLW = $clog2(COLS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            shift_acc,
  input  logic            lp_fall,
  input  logic            wide,
  input  logic            dir,
  input  logic [DW-1:0]   din,
  input  logic [CNTW-1:0] bit_cnt,
  output logic [COLS-1:0] line_q
);
  import seg_chain_pkg::*;

  logic [COLS-1:0] line_d;
  logic [DW-1:0]   din_g;

  // Data path held low unless a word is being taken.
  assign din_g = shift_acc ? din : '0;

  always_comb begin
    line_d = line_q;
    if (lp_fall) begin
      line_d = '0;
    end else if (shift_acc) begin
      for (int j = 0; j < int'(DW); j++) begin
        if (j < word_bits(DW, wide)) begin
          line_d[COLW'(col_pos(COLS, int'(bit_cnt), j, dir))] =
            din_g[word_bits(DW, wide) - 1 - j];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= '0;
    else        line_q <= line_d;
  end
endmodule

// File: rtl/seg_line_stage.sv
module seg_line_stage #(
  parameter int unsigned COLS  = 160,
  parameter int unsigned LINES = 4,
  parameter int unsigned ROWW  = 8,
  localparam int unsigned LIW  = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  lp_fall,
  input  logic [COLS-1:0]       line_q,
  input  logic [ROWW-1:0]       row_addr,
  output logic                  mem_we,
  output logic [ROWW-1:0]       mem_row,
  output logic [LINES*COLS-1:0] mem_blk
);
  logic [LIW-1:0]  lidx;
  logic            last_line;
  logic [COLS-1:0] slot [LINES-1];

  assign last_line = (lidx == LIW'(LINES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lidx <= '0;
    else if (lp_fall) lidx <= last_line ? '0 : lidx + 1'b1;
  end

  generate
    for (genvar s = 0; s < int'(LINES) - 1; s++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                slot[s] <= '0;
        else if (lp_fall && lidx == LIW'(s))       slot[s] <= line_q;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_we  <= 1'b0;
      mem_row <= '0;
      mem_blk <= '0;
    end else begin
      mem_we <= lp_fall & last_line;
      if (lp_fall && last_line) begin
        mem_row <= row_addr;
        for (int s = 0; s < int'(LINES) - 1; s++)
          mem_blk[s*COLS +: COLS] <= slot[s];
        mem_blk[(LINES-1)*COLS +: COLS] <= line_q;
      end
    end
  end
endmodule

// File: rtl/seg_chain_in.sv
module seg_chain_in #(
  parameter int unsigned COLS  = seg_chain_pkg::DEF_COLS,
  parameter int unsigned LINES = seg_chain_pkg::DEF_LINES,
  parameter int unsigned DW    = seg_chain_pkg::DEF_DW,
  parameter int unsigned ROWW  = seg_chain_pkg::DEF_ROWW,
  localparam int unsigned CNTW = $clog2(COLS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sclk,
  input  logic                  lp,
  input  logic [DW-1:0]         din,
  input  logic                  wide,
  input  logic                  dir,
  input  logic [ROWW-1:0]       row_addr,
  input  logic                  ena_a_in,
  input  logic                  ena_b_in,
  output logic                  ena_a_out,
  output logic                  ena_a_oe,
  output logic                  ena_b_out,
  output logic                  ena_b_oe,
  output logic                  mem_we,
  output logic [ROWW-1:0]       mem_row,
  output logic [LINES*COLS-1:0] mem_blk
);
  // Internal events, named for the checker.
  logic            sclk_fall;
  logic            lp_fall;
  logic            shift_acc;
  logic            tok_n;
  logic [CNTW-1:0] bit_cnt;
  logic [COLS-1:0] line_q;

  seg_edge_det #(.FALLING(1'b1)) u_sclk_edge (
    .clk(clk), .rst_n(rst_n), .sig(sclk), .pulse(sclk_fall));

  seg_edge_det #(.FALLING(1'b1)) u_lp_edge (
    .clk(clk), .rst_n(rst_n), .sig(lp), .pulse(lp_fall));

  seg_enable_ctl #(.COLS(COLS), .DW(DW)) u_enable (
    .clk(clk), .rst_n(rst_n), .dir(dir), .wide(wide),
    .ena_a_in(ena_a_in), .ena_b_in(ena_b_in),
    .sclk_fall(sclk_fall), .lp_fall(lp_fall),
    .shift_acc(shift_acc), .bit_cnt(bit_cnt), .tok_n(tok_n),
    .oe_a(ena_a_oe), .oe_b(ena_b_oe));

  seg_line_asm #(.COLS(COLS), .DW(DW)) u_line (
    .clk(clk), .rst_n(rst_n), .shift_acc(shift_acc), .lp_fall(lp_fall),
    .wide(wide), .dir(dir), .din(din), .bit_cnt(bit_cnt), .line_q(line_q));

  seg_line_stage #(.COLS(COLS), .LINES(LINES), .ROWW(ROWW)) u_stage (
    .clk(clk), .rst_n(rst_n), .lp_fall(lp_fall), .line_q(line_q),
    .row_addr(row_addr), .mem_we(mem_we), .mem_row(mem_row),
    .mem_blk(mem_blk));

  assign ena_a_out = tok_n;
  assign ena_b_out = tok_n;
endmodule

// File: rtl/seg_chain_in_chk.sv
module seg_chain_in_chk #(
  parameter int unsigned COLS  = 160,
  parameter int unsigned LINES = 4,
  parameter int unsigned DW    = 8,
  localparam int unsigned CNTW = $clog2(COLS + 1)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  dir,
  input logic                  wide,
  input logic                  ena_a_in,
  input logic                  ena_b_in,
  input logic                  ena_a_out,
  input logic                  ena_b_out,
  input logic                  ena_a_oe,
  input logic                  ena_b_oe,
  input logic                  shift_acc,
  input logic                  lp_fall,
  input logic [CNTW-1:0]       bit_cnt,
  input logic                  mem_we,
  input logic [LINES*COLS-1:0] mem_blk
);
  logic tok_pin;
  int   step;

  assign tok_pin = dir ? ena_b_out : ena_a_out;
  assign step    = wide ? int'(DW) : int'(DW) / 2;

  AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ena_a_oe, ena_b_oe}) == 1);                     // R2

  AST_NO_TAKE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    shift_acc |-> ((dir ? ena_a_in : ena_b_in) == 1'b0));       // R3

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(bit_cnt) <= int'(COLS));                              // R7

  AST_TOKEN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_acc && int'(bit_cnt) + step == int'(COLS)) |=> !tok_pin); // R7

  AST_TOKEN_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    lp_fall |=> tok_pin);                                       // R8

  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);                                        // R9

  AST_WE_AFTER_LP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(lp_fall));                                 // R9

  AST_BLK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we |-> $stable(mem_blk));                              // R9
endmodule

bind seg_chain_in seg_chain_in_chk #(.COLS(COLS), .LINES(LINES), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .dir(dir), .wide(wide),
  .ena_a_in(ena_a_in), .ena_b_in(ena_b_in),
  .ena_a_out(ena_a_out), .ena_b_out(ena_b_out),
  .ena_a_oe(ena_a_oe), .ena_b_oe(ena_b_oe),
  .shift_acc(shift_acc), .lp_fall(lp_fall), .bit_cnt(bit_cnt),
  .mem_we(mem_we), .mem_blk(mem_blk));

// File: tb/tb_seg_chain_in.sv
`timescale 1ns/1ps
module tb_seg_chain_in;
  localparam int COLS = 160;
  localparam int LINES = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, lp = 1'b0, wide = 1'b1, dir = 1'b0;
  logic [7:0] din = '0;
  logic [7:0] row_addr = '0;
  logic ena_a_in = 1'b1, ena_b_in = 1'b0;
  logic ena_a_out, ena_a_oe, ena_b_out, ena_b_oe, mem_we;
  logic [7:0] mem_row;
  logic [LINES*COLS-1:0] mem_blk;

  int vectors = 0;
  int miscompares = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  seg_chain_in dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .lp(lp), .din(din), .wide(wide),
    .dir(dir), .row_addr(row_addr), .ena_a_in(ena_a_in), .ena_b_in(ena_b_in),
    .ena_a_out(ena_a_out), .ena_a_oe(ena_a_oe), .ena_b_out(ena_b_out),
    .ena_b_oe(ena_b_oe), .mem_we(mem_we), .mem_row(mem_row), .mem_blk(mem_blk));

  // Behavioural reference: arrival-ordered bit queue, lines placed at strobe.
  bit              q[$];
  logic [COLS-1:0] m_lines [LINES];
  int              m_lidx;
  logic            m_sclk_p, m_lp_p;
  logic            e_we;
  logic [7:0]      e_row;
  logic [LINES*COLS-1:0] e_blk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete(); m_lidx = 0; m_sclk_p = 0; m_lp_p = 0;
      e_we = 0; e_row = '0; e_blk = '0;
    end else begin
      automatic logic lpf = m_lp_p && !lp;
      automatic logic sf  = m_sclk_p && !sclk;
      automatic logic en  = dir ? !ena_a_in : !ena_b_in;
      automatic int   w   = wide ? 8 : 4;
      e_we = 0;
      if (lpf) begin
        automatic logic [COLS-1:0] ln = '0;
        foreach (q[k]) ln[dir ? k : COLS - 1 - k] = q[k];
        m_lines[m_lidx] = ln;
        m_lidx++;
        if (m_lidx == LINES) begin
          for (int i = 0; i < LINES; i++) e_blk[i*COLS +: COLS] = m_lines[i];
          e_row = row_addr; e_we = 1; m_lidx = 0;
        end
        q.delete();
      end else if (sf && en && q.size() < COLS) begin
        for (int j = 0; j < w; j++) q.push_back(din[w-1-j]);
      end
      m_sclk_p = sclk; m_lp_p = lp;
    end
  end

  task automatic cmp(input string what, input logic [LINES*COLS-1:0] act,
                     input logic [LINES*COLS-1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    automatic logic tok = (q.size() == COLS) ? 1'b0 : 1'b1;
    cmp("token_a_oe R2", ena_a_oe, !dir);
    cmp("token_b_oe R2", ena_b_oe, dir);
    cmp("token_out R7/R8", dir ? ena_b_out : ena_a_out, tok);
    cmp("mem_we R9", mem_we, e_we);
    cmp("mem_row R9", mem_row, e_row);
    cmp("mem_blk R6", mem_blk, e_blk);
  end

  task automatic tick(); @(negedge clk); #1; endtask

  task automatic shift(input logic [7:0] d);
    tick(); din = d; sclk = 1'b1;
    tick(); sclk = 1'b0;
  endtask

  task automatic strobe(input logic [7:0] row);
    tick(); lp = 1'b1; row_addr = row;
    tick(); lp = 1'b0;
    tick(); tick();
  endtask

  task automatic send_line(input int words, input int seed);
    for (int i = 0; i < words; i++) shift(8'((i * 37 + seed * 11 + 5) & 255));
  endtask

  initial begin
    fork
      begin : main
        repeat (3) tick();
        cur_req = "R1";                          // reset state
        repeat (2) tick();
        rst_n = 1'b1;
        repeat (2) tick();

        // R5 / R6 / R7 / R9: byte mode, fill from top column, extra words ignored
        cur_req = "R5"; wide = 1; dir = 0; ena_b_in = 0; ena_a_in = 1;
        for (int l = 0; l < LINES; l++) begin
          send_line(COLS / 8, l);
          cur_req = "R7";
          shift(8'hFF); shift(8'hA5);            // after full line: ignored
          strobe(8'(l + 3));
          cur_req = "R8";
        end

        // R4 / R6 / R2: nibble mode, forward fill, input on pin A, high nibble junk
        cur_req = "R4"; wide = 0; dir = 1; ena_a_in = 0; ena_b_in = 1;
        tick();
        for (int l = 0; l < LINES; l++) begin
          for (int i = 0; i < COLS / 4; i++)
            shift({4'((i * 7 + l) & 15), 4'((i * 5 + l * 3) & 15)});
          strobe(8'(l + 40));
        end

        // R3: one real line, then words with token high or on the wrong pin
        cur_req = "R3"; wide = 1; dir = 0; ena_b_in = 0; ena_a_in = 1;
        send_line(COLS / 8, 9);
        strobe(8'h10);
        ena_b_in = 1;
        send_line(10, 2);
        strobe(8'h11);
        ena_a_in = 0;                            // unselected pin low
        send_line(10, 3);
        strobe(8'h12);
        ena_a_in = 1; ena_b_in = 0;
        send_line(7, 4);                         // partial line, rest zero
        strobe(8'h13);

        // R8: strobe coincident with a shift edge drops that word
        cur_req = "R8";
        send_line(3, 6);
        tick(); din = 8'hC3; sclk = 1; lp = 1;
        tick(); sclk = 0; lp = 0;
        send_line(2, 7);
        strobe(8'h20); strobe(8'h21); strobe(8'h22);
        strobe(8'h23);
        repeat (4) tick();
        disable wd;
      end
      begin : wd
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        disable main;
      end
    join
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule